// File: doc/BRIEF.md
# ADC Host Sequencer Controller

This block sits on the host side of a serial 12-bit converter that starts a conversion on a rising edge of its start input. It runs conversions back to back from a system clock. It raises and lowers the start line, waits out the conversion, and then clocks one 16-edge-pair-free transfer of 12 serial clock pulses. During that transfer it shifts a 6-bit channel setup word out to the converter and collects the 12 result bits coming back.

Channel setups arrive on a valid/ready request port. When no request is pending, the setup used last time is sent again. The converter applies a setup to the conversion that follows the transfer that carried it. For this reason each result is labelled with the setup sent one transfer earlier. The first result after reset comes from an unknown setup and is marked stale.

A mode input chooses between two start-line styles. In the short-pulse style the line is pulsed briefly. In the long-pulse style the line is held high until the conversion is over, so the converter sleeps between samples. Every timing quantity is a parameter counted in system-clock cycles. A parameter set below its physical minimum is raised to that minimum when the block is elaborated.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While rst_ni is low, and afterwards for as long as enable_i stays low, convst_o, sck_o, sdi_o, req_ready_o and result_valid_o are all 0 and no conversion starts.
- R2: Rising edges of convst_o are at least PER_EFF cycles apart (250 with defaults). While enable_i stays high they are exactly that far apart.
- R3: In short-pulse mode (long_mode_i = 0 when the conversion starts), convst_o stays high for exactly HI_CYC cycles (2 at a 10 ns clock).
- R4: In long-pulse mode (long_mode_i = 1 when the conversion starts), convst_o stays high for exactly CONV_EFF cycles (160 with defaults) and then goes low before the transfer begins.
- R5: Each transfer has exactly 12 sck_o pulses. The first rising sck_o edge comes at least CONV_EFF cycles after the convst_o rising edge, and convst_o is low at every sck_o edge.
- R6: sdi_o is taken at rising sck_o edges. At rises 1 to 6 it carries req_cfg bit 2 (single-ended), bit 1 (odd/sign), 0, 0, bit 0 (unipolar), 0, in that order. At rises 7 to 12 it is 0.
- R7: result_data_o holds the 12 sdo_i bits sampled at the 12 rising sck_o edges. The first sampled bit lands in bit 11.
- R8: At least ACQ_EFF cycles (24 at a 10 ns clock) pass between the seventh rising sck_o edge of a transfer and the next convst_o rising edge.
- R9: result_cfg_o equals the setup sent in the previous transfer. result_stale_o is 1 for the first result after reset and 0 for every later result.
- R10: req_ready_o pulses for one cycle as a transfer begins, and a request accepted then is the setup sent in that transfer. If req_valid_i is low at that point, the previously sent setup is sent again.
- R11: A timing parameter below its minimum is raised to the minimum. With the defaults (SCK_HALF 1, CONV_CYC 100, CLK_NS 10) the sck_o half period is 2 cycles and the conversion wait is 160 cycles.
- R12: result_valid_o is a single-cycle pulse, once per transfer, raised at the last falling sck_o edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run conversions repeatedly while high |
| long_mode_i | input | 1 | 1 = hold the start line through the conversion (sleep); 0 = short pulse |
| req_valid_i | input | 1 | A channel setup is offered |
| req_cfg_i | input | 3 | Setup: [2] single-ended, [1] odd/sign, [0] unipolar |
| req_ready_o | output | 1 | Setup accepted this cycle |
| convst_o | output | 1 | Conversion start line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial setup data to the converter |
| sdo_i | input | 1 | Serial result data from the converter |
| result_valid_o | output | 1 | Result strobe |
| result_data_o | output | 12 | Captured result, MSB first on the wire |
| result_cfg_o | output | 3 | Setup that produced this result |
| result_stale_o | output | 1 | Result comes from an unknown setup |

## Verification
A behavioural converter model in the bench returns different 12-bit codes for each conversion: all ones, all zeros, a word with only both end bits set, and mixed values that depend on the setup. These codes expose bit-order, shift-count and off-by-one capture faults. The bench sends a series of distinct setups and then a stretch with no request at all. The first part separates the one-transfer tag delay from an undelayed tag. The second shows whether the last setup is held. The same traffic is run in short-pulse and long-pulse mode, so that the pulse widths and the conversion wait are measured against the different limits of each mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CFG_W = 6;

  typedef struct packed {
    logic single_ended;
    logic odd_sign;
    logic unipolar;
  } chan_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_WAIT, ST_XFER} seq_state_e;

  // wire order: single_ended, odd_sign, x, x, unipolar, x
  function automatic logic [CFG_W-1:0] cfg_to_word(chan_cfg_t c);
    return {c.single_ended, c.odd_sign, 2'b00, c.unipolar, 1'b0};
  endfunction

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_seq_sck.sv
module adc_seq_sck #(
  parameter int unsigned HALF  = 2,
  parameter int unsigned NRISE = 12,
  localparam int unsigned HW   = $clog2(HALF + 1),
  localparam int unsigned IW   = $clog2(NRISE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          sck_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic          done_o,
  output logic [IW-1:0] rise_idx_o
);
  logic          active_q, sck_q, tick;
  logic [HW-1:0] hcnt_q;
  logic [IW-1:0] nrise_q;

  assign tick       = active_q && (hcnt_q == HW'(HALF - 1));
  assign rise_o     = tick && !sck_q;
  assign fall_o     = tick && sck_q;
  assign done_o     = fall_o && (nrise_q == IW'(NRISE));
  assign sck_o      = sck_q;
  assign rise_idx_o = nrise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      hcnt_q   <= '0;
      nrise_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sck_q    <= 1'b0;
      hcnt_q   <= '0;
      nrise_q  <= '0;
    end else if (active_q) begin
      if (tick) begin
        hcnt_q <= '0;
        sck_q  <= !sck_q;
        if (rise_o) nrise_q <= nrise_q + 1'b1;
        if (done_o) active_q <= 1'b0;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  p_sck_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sck_q);
  p_rise_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (nrise_q < IW'(NRISE)));
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int unsigned OUT_W = 6,
  parameter int unsigned IN_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OUT_W-1:0] word_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sdo_i,
  output logic             sdi_o,
  output logic [IN_W-1:0]  data_o
);
  logic [OUT_W-1:0] out_q;
  logic [IN_W-1:0]  in_q;

  assign sdi_o  = out_q[OUT_W-1];
  assign data_o = in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (load_i)      out_q <= word_i;
      else if (fall_i) out_q <= out_q << 1;
      if (rise_i)      in_q  <= {in_q[IN_W-2:0], sdo_i};
    end
  end

  p_sdi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !load_i) |=> $stable(sdi_o));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned SCK_HALF   = 1,
  parameter int unsigned CONV_CYC   = 100,
  parameter int unsigned PERIOD_CYC = 250,
  parameter int unsigned DATA_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              long_mode_i,
  input  logic              req_valid_i,
  input  logic [2:0]        req_cfg_i,
  output logic              req_ready_o,
  output logic              convst_o,
  output logic              sck_o,
  output logic              sdi_o,
  input  logic              sdo_i,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_data_o,
  output logic [2:0]        result_cfg_o,
  output logic              result_stale_o
);
  // minima: 40 MHz SCK, 1.6 us conversion, 240 ns acquisition, 20 ns pulse, 2 us cycle
  localparam int unsigned SCK_EFF  = max_u(SCK_HALF, ceil_div(25, 2 * CLK_NS));
  localparam int unsigned CONV_EFF = max_u(CONV_CYC, ceil_div(1600, CLK_NS));
  localparam int unsigned ACQ_EFF  = ceil_div(240, CLK_NS);
  localparam int unsigned HI_CYC   = max_u(1, ceil_div(20, CLK_NS));
  localparam int unsigned LEAD     = max_u(1, ceil_div(20, CLK_NS));
  localparam int unsigned PER_EFF  = max_u(PERIOD_CYC,
                                      max_u(ceil_div(2000, CLK_NS), CONV_EFF + LEAD + 1));
  localparam int unsigned PW = $clog2(PER_EFF + 1);
  localparam int unsigned AW = $clog2(ACQ_EFF + 1);
  localparam int unsigned IW = $clog2(DATA_W + 1);

  seq_state_e        state_q;
  logic [PW-1:0]     per_cnt_q;
  logic [AW-1:0]     acq_cnt_q;
  logic              convst_q, long_q, have_prev_q;
  chan_cfg_t         last_cfg_q, sent_cfg_q, prev_cfg_q, res_cfg_q, cfg_now;
  logic              res_valid_q, res_stale_q;
  logic [DATA_W-1:0] res_data_q, shift_data;
  logic              start_cnv, drop_cnv, go_xfer, seventh;
  logic              sck_rise, sck_fall, xfer_done;
  logic [IW-1:0]     rise_idx;

  assign cfg_now   = req_valid_i ? chan_cfg_t'(req_cfg_i) : last_cfg_q;
  assign start_cnv = (state_q == ST_IDLE) && enable_i &&
                     (per_cnt_q == PW'(PER_EFF - 1)) && (acq_cnt_q == AW'(ACQ_EFF));
  assign drop_cnv  = (state_q == ST_PULSE) &&
                     (per_cnt_q == (long_q ? PW'(CONV_EFF - 1) : PW'(HI_CYC - 1)));
  assign go_xfer   = (state_q == ST_WAIT) && (per_cnt_q == PW'(CONV_EFF + LEAD - 1));
  assign seventh   = sck_rise && (rise_idx == IW'(CFG_W));

  adc_seq_sck #(.HALF(SCK_EFF), .NRISE(DATA_W)) u_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(go_xfer), .sck_o(sck_o),
    .rise_o(sck_rise), .fall_o(sck_fall), .done_o(xfer_done), .rise_idx_o(rise_idx)
  );

  adc_seq_shift #(.OUT_W(CFG_W), .IN_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go_xfer), .word_i(cfg_to_word(cfg_now)),
    .rise_i(sck_rise), .fall_i(sck_fall), .sdo_i(sdo_i), .sdi_o(sdi_o), .data_o(shift_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      per_cnt_q   <= PW'(PER_EFF - 1);
      acq_cnt_q   <= AW'(ACQ_EFF);
      convst_q    <= 1'b0;
      long_q      <= 1'b0;
      have_prev_q <= 1'b0;
      last_cfg_q  <= '0;
      sent_cfg_q  <= '0;
      prev_cfg_q  <= '0;
      res_cfg_q   <= '0;
      res_valid_q <= 1'b0;
      res_stale_q <= 1'b0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (per_cnt_q != PW'(PER_EFF - 1)) per_cnt_q <= per_cnt_q + 1'b1;
      if (seventh) acq_cnt_q <= '0;
      else if (acq_cnt_q != AW'(ACQ_EFF)) acq_cnt_q <= acq_cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: if (start_cnv) begin
          state_q   <= ST_PULSE;
          convst_q  <= 1'b1;
          per_cnt_q <= '0;
          long_q    <= long_mode_i;
        end
        ST_PULSE: if (drop_cnv) begin
          convst_q <= 1'b0;
          state_q  <= ST_WAIT;
        end
        ST_WAIT: if (go_xfer) begin
          state_q    <= ST_XFER;
          last_cfg_q <= cfg_now;
          sent_cfg_q <= cfg_now;
        end
        ST_XFER: if (xfer_done) begin
          state_q     <= ST_IDLE;
          res_valid_q <= 1'b1;
          res_data_q  <= shift_data;
          res_cfg_q   <= prev_cfg_q;
          res_stale_q <= !have_prev_q;
          prev_cfg_q  <= sent_cfg_q;
          have_prev_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = go_xfer;
  assign convst_o       = convst_q;
  assign result_valid_o = res_valid_q;
  assign result_data_o  = res_data_q;
  assign result_cfg_o   = res_cfg_q;
  assign result_stale_o = res_stale_q;

  p_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_o) |-> ($past(per_cnt_q) == PW'(PER_EFF - 1)));
  p_acq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_o) |-> ($past(acq_cnt_q) == AW'(ACQ_EFF)));
  p_short_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(convst_o) && !long_q) |-> (per_cnt_q == PW'(HI_CYC)));
  p_long_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(convst_o) && long_q) |-> (per_cnt_q == PW'(CONV_EFF)));
  p_cs_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !convst_o);
  p_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!convst_o && !sck_o));
  p_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int E_PER  = 250;
  localparam int E_CONV = 160;
  localparam int E_HI   = 2;
  localparam int E_HALF = 2;
  localparam int E_ACQ  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, long_mode = 1'b0, req_valid = 1'b0;
  logic [2:0] req_cfg = 3'b000;
  logic req_ready, convst, sck, sdi, sdo, res_valid, res_stale;
  logic [11:0] res_data;
  logic [2:0]  res_cfg;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .long_mode_i(long_mode),
    .req_valid_i(req_valid), .req_cfg_i(req_cfg), .req_ready_o(req_ready),
    .convst_o(convst), .sck_o(sck), .sdi_o(sdi), .sdo_i(sdo),
    .result_valid_o(res_valid), .result_data_o(res_data),
    .result_cfg_o(res_cfg), .result_stale_o(res_stale)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] model_val(int idx, logic [2:0] c);
    if (idx == 1) return 12'hFFF;
    if (idx == 2) return 12'h000;
    if (idx == 3) return 12'h801;
    return 12'((idx * 1237 + int'(c) * 389 + 77));
  endfunction

  // converter model and monitors
  int cyc = 0, ncs = 0, last_cs_rise = 0, last_period = 0, last_sck_edge = 0;
  int srise = 0, sfall = 0, r7_cyc = 0, nres = 0, naccept = 0;
  bit seen7 = 0, pc = 0, ps = 0, pv = 0, pr = 0;
  logic [11:0] sr = '0, conv_val = '0;
  logic [5:0]  word = '0;
  logic [2:0]  pend_cfg = '0, conv_cfg = '0, exp_cfg = '0;
  assign sdo = sr[11];

  always @(negedge clk) begin
    cyc++;
    if (req_ready) begin
      chk(!pr, "R10 ready one cycle", int'(pr), 0);
      if (req_valid) begin exp_cfg = req_cfg; naccept++; end
    end
    pr = req_ready;
    if (convst && !pc) begin
      if (ncs > 0) begin
        last_period = cyc - last_cs_rise;
        chk(last_period >= E_PER, "R2 period", last_period, E_PER);
      end
      if (seen7) chk(cyc - r7_cyc >= E_ACQ, "R8 acquisition", cyc - r7_cyc, E_ACQ);
      conv_cfg = pend_cfg;
      conv_val = model_val(ncs, pend_cfg);
      sr = conv_val;
      ncs++;
      last_cs_rise = cyc;
      srise = 0; sfall = 0; seen7 = 0;
    end
    if (!convst && pc) begin
      if (long_mode) chk(cyc - last_cs_rise == E_CONV, "R4 long high", cyc - last_cs_rise, E_CONV);
      else           chk(cyc - last_cs_rise == E_HI, "R3 short high", cyc - last_cs_rise, E_HI);
    end
    if (sck && !ps) begin
      chk(!convst, "R5 convst low at rise", int'(convst), 0);
      if (srise == 0) chk(cyc - last_cs_rise >= E_CONV, "R5 conv wait", cyc - last_cs_rise, E_CONV);
      else chk(cyc - last_sck_edge == E_HALF, "R11 half period", cyc - last_sck_edge, E_HALF);
      if (srise < 6) word[5 - srise] = sdi;
      else chk(sdi == 1'b0, "R6 trailing sdi", int'(sdi), 0);
      srise++;
      if (srise == 7) begin r7_cyc = cyc; seen7 = 1; end
      last_sck_edge = cyc;
    end
    if (!sck && ps) begin
      chk(!convst, "R5 convst low at fall", int'(convst), 0);
      chk(cyc - last_sck_edge == E_HALF, "R11 half period", cyc - last_sck_edge, E_HALF);
      sr = sr << 1;
      sfall++;
      last_sck_edge = cyc;
      if (sfall == 12) begin
        chk(word == {exp_cfg[2], exp_cfg[1], 2'b00, exp_cfg[0], 1'b0}, "R6 word",
            int'(word), int'({exp_cfg[2], exp_cfg[1], 2'b00, exp_cfg[0], 1'b0}));
        pend_cfg = {word[5], word[4], word[1]};
      end
    end
    if (res_valid) begin
      chk(!pv, "R12 single pulse", int'(pv), 0);
      chk(srise == 12 && sfall == 12, "R5 pulse count", srise, 12);
      chk(res_data == conv_val, "R7 data", int'(res_data), int'(conv_val));
      chk(res_stale == (nres == 0), "R9 stale", int'(res_stale), int'(nres == 0));
      if (nres > 0) chk(res_cfg == conv_cfg, "R9 tag", int'(res_cfg), int'(conv_cfg));
      nres++;
    end
    pv = res_valid; pc = convst; ps = sck;
  end

  task automatic send_req(input logic [2:0] c);
    @(posedge clk); #2;
    req_valid = 1'b1; req_cfg = c;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wait_results(input int n, input string tag);
    int target = nres + n;
    for (int t = 0; t < 5000 && nres < target; t++) @(posedge clk);
    chk(nres >= target, tag, nres, target);
  endtask

  task automatic stop_and_idle();
    @(posedge clk); #2;
    enable = 1'b0;
    repeat (600) @(posedge clk);
  endtask

  task automatic t_reset();
    chk(!convst && !sck && !sdi && !req_ready && !res_valid, "R1 in reset",
        {convst, sck, sdi, req_ready, res_valid}, 0);
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (300) @(posedge clk);
    chk(ncs == 0, "R1 no start while disabled", ncs, 0);
    chk(!convst && !sck && !sdi && !res_valid, "R1 idle outputs",
        {convst, sck, sdi, res_valid}, 0);
  endtask

  task automatic t_short();
    int a0 = naccept;
    long_mode = 1'b0;
    #2 enable = 1'b1;
    send_req(3'b101);
    send_req(3'b010);
    send_req(3'b111);
    wait_results(4 - nres, "R9 first results");
    chk(naccept - a0 == 3, "R10 accepted", naccept - a0, 3);
    chk(last_period == E_PER, "R2 steady period", last_period, E_PER);
    stop_and_idle();
  endtask

  task automatic t_repeat();
    int a0 = naccept, c0;
    long_mode = 1'b0;
    #2 enable = 1'b1;
    wait_results(3, "R10 repeated setup results");
    chk(naccept == a0, "R10 no accept without valid", naccept, a0);
    chk(pend_cfg == 3'b111, "R10 setup held", int'(pend_cfg), 7);
    stop_and_idle();
    c0 = ncs;
    repeat (400) @(posedge clk);
    chk(ncs == c0, "R1 stop when disabled", ncs, c0);
  endtask

  task automatic t_long();
    long_mode = 1'b1;
    #2 enable = 1'b1;
    send_req(3'b001);
    send_req(3'b110);
    wait_results(3, "R4 long results");
    chk(last_period == E_PER, "R2 long period", last_period, E_PER);
    stop_and_idle();
    long_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_short();
    t_repeat();
    t_long();
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule